// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel ports, called A and B, and moves data between them in either direction. Each direction has its own capture register with its own clock. For the port it drives, an output multiplexer picks either the live value on the opposite port or the stored copy in that direction's register. An active-low enable and a direction bit decide which port, if any, the block drives. Two independent select bits decide whether each direction sends live or stored data.

The datapath is split into lanes. There are two lanes of 8 bits by default, and each lane has its own enable, direction, pair of capture clocks and pair of selects. Driving every lane with the same controls makes the block act as one full-width transceiver. Each port has an input view, an output view and a drive-enable flag. Together these model a tri-state pin: the pin carries the output view when the flag is set and is high impedance otherwise.

Top module: `xcvr_regbus`

## Requirements
- R1: On each rising edge of a lane's A-to-B clock, that lane's A-to-B register loads the lane's current A-port value. On each rising edge of the B-to-A clock, the B-to-A register loads the B-port value. An edge on one clock leaves the other register unchanged.
- R2: While a lane's enable is high, both drive-enable flags of that lane are 0. Both registers still capture on their clock edges during this time.
- R3: While a lane's enable is low, direction 0 drives port A (A flag 1, B flag 0) and direction 1 drives port B (B flag 1, A flag 0).
- R4: On the driven port, select 0 passes the opposite port's input through combinationally. Select 1 drives that direction's register. The select of the direction that is not driving has no effect.
- R5: A lane never drives both of its ports at once.
- R6: If a capture edge arrives while the block itself drives that port, the register stores the value the block is driving.
- R7: Lane k occupies bits [8k+7:8k] of every bus. Lanes do not affect one another, and identical controls on all lanes give one 16-bit transfer.
- R8: A port that shows stored data shows the register value from the most recent edge, with no added cycle of delay.
- R9: An active-low asynchronous reset clears both registers of every lane to zero.
- R10: The output view of a port that is not driven reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | LANES | Per-lane output enable, active low |
| dir_i | input | LANES | Per-lane direction: 0 drives A, 1 drives B |
| clk_ab_i | input | LANES | Per-lane A-to-B capture clock |
| clk_ba_i | input | LANES | Per-lane B-to-A capture clock |
| sel_ab_i | input | LANES | Per-lane B-side source: 0 live, 1 stored |
| sel_ba_i | input | LANES | Per-lane A-side source: 0 live, 1 stored |
| a_i | input | LANES*LANE_W | A-port input view |
| b_i | input | LANES*LANE_W | B-port input view |
| a_o | output | LANES*LANE_W | A-port output view |
| a_oe_o | output | LANES | A-port drive enable per lane |
| b_o | output | LANES*LANE_W | B-port output view |
| b_oe_o | output | LANES | B-port drive enable per lane |

## Verification
A table walks one lane through isolation, both directions and both select values. Its port values are chosen so that live data, the A-to-B register and the B-to-A register each hold a different byte, which makes any wrong source visible. Directed tests then give the two lanes opposite directions to expose cross-lane leakage. They capture while the block drives the port, so the register must take the driven value and not the undriven input. They also sample stored output right after a clock edge to catch added latency, and they apply reset while stored mode is selected.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef enum logic {
        DRIVE_A = 1'b0,
        DRIVE_B = 1'b1
    } dir_e;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.data;

    // R1: the stored word is the input seen at the previous edge
    a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (q_o == $past(d_i)));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_ni,
    input  logic         oe_ni,
    input  logic         dir_i,
    input  logic         clk_ab_i,
    input  logic         clk_ba_i,
    input  logic         sel_ab_i,
    input  logic         sel_ba_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic         a_oe_o,
    output logic [W-1:0] b_o,
    output logic         b_oe_o
);

    typedef struct packed {
        logic         a_en;
        logic         b_en;
        logic [W-1:0] a_val;
        logic [W-1:0] b_val;
    } drive_t;

    drive_t       drv_d;
    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;
    logic [W-1:0] a_bus;
    logic [W-1:0] b_bus;

    always_comb begin
        drv_d      = '0;
        drv_d.a_en = !oe_ni && (dir_e'(dir_i) == DRIVE_A);
        drv_d.b_en = !oe_ni && (dir_e'(dir_i) == DRIVE_B);
        if (drv_d.a_en) begin
            drv_d.a_val = (src_sel_e'(sel_ba_i) == SRC_STORED) ? ba_q : b_i;
        end
        if (drv_d.b_en) begin
            drv_d.b_val = (src_sel_e'(sel_ab_i) == SRC_STORED) ? ab_q : a_i;
        end
    end

    // resolved pin values: what a capture edge actually sees on each port
    assign a_bus = drv_d.a_en ? drv_d.a_val : a_i;
    assign b_bus = drv_d.b_en ? drv_d.b_val : b_i;

    xcvr_capture #(.W(W)) u_ab (
        .clk_i (clk_ab_i),
        .rst_ni(rst_ni),
        .d_i   (a_bus),
        .q_o   (ab_q)
    );

    xcvr_capture #(.W(W)) u_ba (
        .clk_i (clk_ba_i),
        .rst_ni(rst_ni),
        .d_i   (b_bus),
        .q_o   (ba_q)
    );

    assign a_o    = drv_d.a_val;
    assign a_oe_o = drv_d.a_en;
    assign b_o    = drv_d.b_val;
    assign b_oe_o = drv_d.b_en;

    always_comb begin
        if (rst_ni) begin
            a_r5_one_driver: assert (!(a_oe_o && b_oe_o));
            if (oe_ni) begin
                a_r2_isolate: assert (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0);
            end
            if (b_oe_o && !sel_ab_i) begin
                a_r4_live_ab: assert (b_o == a_i);
            end
            if (a_oe_o && sel_ba_i) begin
                a_r4_stored_ba: assert (a_o == ba_q);
            end
        end
    end

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    rst_ni,
    input  logic [LANES-1:0]        oe_ni,
    input  logic [LANES-1:0]        dir_i,
    input  logic [LANES-1:0]        clk_ab_i,
    input  logic [LANES-1:0]        clk_ba_i,
    input  logic [LANES-1:0]        sel_ab_i,
    input  logic [LANES-1:0]        sel_ba_i,
    input  logic [LANES*LANE_W-1:0] a_i,
    input  logic [LANES*LANE_W-1:0] b_i,
    output logic [LANES*LANE_W-1:0] a_o,
    output logic [LANES-1:0]        a_oe_o,
    output logic [LANES*LANE_W-1:0] b_o,
    output logic [LANES-1:0]        b_oe_o
);

    localparam int BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] a_drv;
    logic [BUS_W-1:0] b_drv;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .rst_ni  (rst_ni),
            .oe_ni   (oe_ni[k]),
            .dir_i   (dir_i[k]),
            .clk_ab_i(clk_ab_i[k]),
            .clk_ba_i(clk_ba_i[k]),
            .sel_ab_i(sel_ab_i[k]),
            .sel_ba_i(sel_ba_i[k]),
            .a_i     (a_i[k*LANE_W +: LANE_W]),
            .b_i     (b_i[k*LANE_W +: LANE_W]),
            .a_o     (a_drv[k*LANE_W +: LANE_W]),
            .a_oe_o  (a_oe_o[k]),
            .b_o     (b_drv[k*LANE_W +: LANE_W]),
            .b_oe_o  (b_oe_o[k])
        );
    end

    assign a_o = a_drv;
    assign b_o = b_drv;

endmodule

// File: tb/sim_xcvr_regbus.sv
module sim_xcvr_regbus;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  oe_n, dir, cab, cba, sab, sba;
    logic [15:0] a_in, b_in;
    wire  [15:0] a_out, b_out;
    wire  [1:0]  a_oe, b_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xcvr_regbus u0 (
        .rst_ni  (rst_n),
        .oe_ni   (oe_n),
        .dir_i   (dir),
        .clk_ab_i(cab),
        .clk_ba_i(cba),
        .sel_ab_i(sab),
        .sel_ba_i(sba),
        .a_i     (a_in),
        .b_i     (b_in),
        .a_o     (a_out),
        .a_oe_o  (a_oe),
        .b_o     (b_out),
        .b_oe_o  (b_oe)
    );

    // {oe_n, dir, sel_ab, sel_ba, a, b, exp_a_oe, exp_b_oe, exp_a, exp_b}
    // lane 0, registers preloaded with A-to-B 3C and B-to-A C3
    localparam logic [37:0] TBL [8] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b1, 1'b0, 8'h22, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h22, 1'b1, 1'b0, 8'hC3, 8'h00},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h11},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h22, 1'b0, 1'b1, 8'h00, 8'h3C},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h22, 1'b0, 1'b1, 8'h00, 8'hFF},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(input logic [1:0] ab, input logic [1:0] ba);
        @(negedge clk);
        cab = ab;
        cba = ba;
        @(negedge clk);
        cab = 2'b00;
        cba = 2'b00;
        #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 2'b11; dir = 2'b00; cab = 2'b00; cba = 2'b00;
        sab = 2'b00; sba = 2'b00; a_in = 16'h0; b_in = 16'h0;
        repeat (3) step();
        check("R2 R10 reset isolated", {a_oe, b_oe, a_out, b_out}, 36'h0);

        // R9: stored mode during reset shows cleared registers
        oe_n = 2'b00; dir = 2'b11; sab = 2'b11;
        step();
        check("R9 cleared AB registers", {b_oe, b_out}, {2'b11, 16'h0000});
        dir = 2'b00; sba = 2'b11;
        step();
        check("R9 cleared BA registers", {a_oe, a_out}, {2'b11, 16'h0000});

        rst_n = 1'b1; oe_n = 2'b11; dir = 2'b00; sab = 2'b00; sba = 2'b00;
        a_in = 16'h5A3C; b_in = 16'hA5C3;
        step();
        pulse(2'b11, 2'b11);
        check("R2 isolated while capturing", {a_oe, b_oe, a_out, b_out}, 36'h0);

        // table walk on lane 0, lane 1 kept isolated
        for (int i = 0; i < 8; i++) begin
            oe_n = {1'b1, TBL[i][37]};
            dir  = {1'b0, TBL[i][36]};
            sab  = {1'b0, TBL[i][35]};
            sba  = {1'b0, TBL[i][34]};
            a_in = {8'h00, TBL[i][33:26]};
            b_in = {8'h00, TBL[i][25:18]};
            step();
            check($sformatf("R3 R4 R10 vector %0d", i),
                  {18'h0, a_oe[0], b_oe[0], a_out[7:0], b_out[7:0]},
                  {18'h0, TBL[i][17:0]});
        end
        check("R7 lane 1 untouched by lane 0", {a_oe[1], b_oe[1], a_out[15:8], b_out[15:8]}, 18'h0);

        // R7: lanes in opposite directions, both stored
        oe_n = 2'b00; dir = 2'b01; sab = 2'b01; sba = 2'b10;
        a_in = 16'h0; b_in = 16'h0;
        step();
        check("R7 split lanes", {a_oe, b_oe, a_out, b_out}, {2'b10, 2'b01, 16'hA500, 16'h003C});

        // R6: capture while the block drives port A
        oe_n = 2'b10; dir = 2'b00; sab = 2'b00; sba = 2'b00; b_in = 16'h0066; a_in = 16'h00EE;
        step();
        check("R4 live B to A", {a_oe, a_out}, {2'b01, 16'h0066});
        pulse(2'b01, 2'b00);
        dir = 2'b01; sab = 2'b01;
        step();
        check("R6 captured driven value", {b_oe, b_out}, {2'b01, 16'h0066});

        // R1: B-to-A register unaffected by the A-to-B edge
        dir = 2'b00; sba = 2'b01;
        step();
        check("R1 other register kept", a_out, 16'h00C3);

        // R8: stored output follows the edge without delay
        dir = 2'b01; sab = 2'b01; a_in = 16'h0099;
        step();
        check("R8 stored output before edge", b_out, 16'h0066);
        @(negedge clk);
        cab = 2'b01;
        #1;
        check("R8 stored output after edge", b_out, 16'h0099);
        cab = 2'b00;

        // R7: one 16-bit transfer
        oe_n = 2'b00; dir = 2'b11; sab = 2'b00; sba = 2'b00; a_in = 16'hBEEF;
        step();
        check("R7 full width live", {a_oe, b_oe, a_out, b_out}, {2'b00, 2'b11, 16'h0000, 16'hBEEF});

        // R9: reset during operation
        sab = 2'b11;
        step();
        check("R1 both lanes stored", b_out, 16'h5A99);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", b_out, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule